// File: doc/BRIEF.md
# Block Gap Pause and Resume Controller

This controller sits beside the data engine of a card host and lets software halt a multi-block transfer at a clean boundary between two blocks, then restart it later. A software stop request is a level. It does not halt anything at once. The halt happens on the next block-done strobe from the data path. While halted, the block holds the engine with a pause output. For reads it can also drive a read-wait period toward the card, and in 4-bit mode it can open a window for detecting a card interrupt during the gap.

A restart is requested through a continue bit. The write is accepted only while the stop request is low. The continue bit then stays set until the data path reports that the data line or the write transfer is active again, and then it clears itself. A block-done strobe that comes with the last-block flag ends the transfer instead, with a one-cycle completion pulse. The transfer options (direction, read-wait enable, gap-interrupt enable and bus width) are captured when the transfer starts.

All pins are plain control and status levels or single-cycle strobes. No data passes through the block, so it has no valid/ready stream interface and applies no back-pressure.

Top module: `gap_pause_ctrl`

## Requirements
- R1: After reset, pause, read_wait, gap_irq_win, data_wr_block, cont_bit and xfer_done are all 0, and the controller is idle.
- R2: A xfer_start strobe while idle begins a transfer. In a running transfer, a blk_done strobe with stop_req=0 and last_blk=0 leaves pause at 0.
- R3: Raising stop_req does not pause at once. pause goes to 1 in the cycle after the next blk_done strobe (with last_blk=0) that is seen while stop_req=1.
- R4: A blk_done with last_blk=1 during a running transfer gives xfer_done=1 for exactly one cycle, starting the cycle after the strobe, and returns to idle without pausing, even when stop_req=1.
- R5: While paused, a cont_wr strobe with stop_req=0 sets cont_bit to 1 and drops pause to 0 in the next cycle.
- R6: While paused, a cont_wr strobe with stop_req=1 is ignored: pause stays 1 and cont_bit stays 0.
- R7: Once set, cont_bit stays 1 until a cycle in which dat_active or wr_active is 1. It reads 0 in the cycle after that one, and the transfer is running again.
- R8: read_wait is 1 exactly while paused in a transfer that was started with dir_read=1 and rdwait_en=1. A paused read with rdwait_en=0 still pauses but leaves read_wait at 0.
- R9: gap_irq_win is 1 exactly while paused in a transfer that was started with bus_wide4=1 and gapirq_en=1.
- R10: data_wr_block equals stop_req while a transfer is in progress (running, paused or resuming) and is 0 when idle.
- R11: A xfer_start strobe while a transfer is in progress has no effect. A paused transfer stays paused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| xfer_start | input | 1 | Strobe: begin a transfer and capture its options |
| dir_read | input | 1 | Transfer direction, 1 = read |
| rdwait_en | input | 1 | Read-wait control enable |
| gapirq_en | input | 1 | Enable for card interrupt detection at the block gap |
| bus_wide4 | input | 1 | 1 = 4-bit data bus, 0 = 1-bit |
| stop_req | input | 1 | Software stop-at-gap request (level) |
| cont_wr | input | 1 | Strobe: software writes 1 to the continue bit |
| blk_done | input | 1 | Strobe from the data path: a block has finished |
| last_blk | input | 1 | Qualifies blk_done as the final block |
| dat_active | input | 1 | Data line active status |
| wr_active | input | 1 | Write transfer active status |
| pause | output | 1 | Hold request to the data engine |
| read_wait | output | 1 | Read-wait period toward the card |
| gap_irq_win | output | 1 | Card interrupt detection window at the gap |
| data_wr_block | output | 1 | Blocks writes to the data port |
| cont_bit | output | 1 | Self-clearing continue bit |
| xfer_done | output | 1 | One-cycle transfer-complete pulse |

## Verification
The assertions assume that blk_done and cont_wr are single-cycle strobes and that the status inputs dat_active and wr_active only go high once a restart has been accepted. They also assume the transfer options stay steady around xfer_start. The stimulus applies each strobe for exactly one cycle and raises an activity status only after cont_bit has been seen set. It sweeps all sixteen combinations of direction, read-wait enable, gap-interrupt enable and bus width, and in half of them it finishes with stop_req still set, to test the last-block priority.

// File: rtl/gpc_pkg.sv
package gpc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_XFER   = 2'd1,
    ST_GAP    = 2'd2,
    ST_RESUME = 2'd3
  } gpc_state_e;

  typedef struct packed {
    logic rd;
    logic rw_en;
    logic irq_en;
    logic wide4;
  } gpc_cfg_t;

  localparam int CFG_W = $bits(gpc_cfg_t);
endpackage

// File: rtl/gpc_seq.sv
module gpc_seq
  import gpc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       blk_done,
  input  logic       last_blk,
  input  logic       stop_req,
  input  logic       cont_accept,
  input  logic       restarted,
  output gpc_state_e state,
  output logic       done_pulse
);
  gpc_state_e nxt;
  logic       fin;

  assign fin = (state == ST_XFER) && blk_done && last_blk;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:   if (start) nxt = ST_XFER;
      ST_XFER: begin
        if (fin)                      nxt = ST_IDLE;
        else if (blk_done && stop_req) nxt = ST_GAP;
      end
      ST_GAP:    if (cont_accept) nxt = ST_RESUME;
      ST_RESUME: if (restarted)   nxt = ST_XFER;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      done_pulse <= 1'b0;
    end else begin
      state      <= nxt;
      done_pulse <= fin;
    end
  end
endmodule

// File: rtl/gpc_cont.sv
module gpc_cont
  import gpc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  gpc_state_e state,
  input  logic       cont_wr,
  input  logic       stop_req,
  input  logic       dat_active,
  input  logic       wr_active,
  output logic       cont_accept,
  output logic       restarted,
  output logic       cont_bit
);
  assign cont_accept = cont_wr && !stop_req && (state == ST_GAP);
  assign restarted   = cont_bit && (dat_active || wr_active);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cont_bit <= 1'b0;
    else if (cont_accept) cont_bit <= 1'b1;
    else if (restarted)   cont_bit <= 1'b0;
  end
endmodule

// File: rtl/gpc_outs.sv
module gpc_outs
  import gpc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  gpc_state_e state,
  input  logic       start,
  input  gpc_cfg_t   cfg_in,
  input  logic       stop_req,
  output logic       pause,
  output logic       read_wait,
  output logic       gap_irq_win,
  output logic       data_wr_block
);
  gpc_cfg_t cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           cfg_q <= '0;
    else if (start && state == ST_IDLE)   cfg_q <= cfg_in;
  end

  assign pause         = (state == ST_GAP);
  assign read_wait     = pause && cfg_q.rd && cfg_q.rw_en;
  assign gap_irq_win   = pause && cfg_q.wide4 && cfg_q.irq_en;
  assign data_wr_block = stop_req && (state != ST_IDLE);
endmodule

// File: rtl/gap_pause_ctrl.sv
module gap_pause_ctrl
  import gpc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic xfer_start,
  input  logic dir_read,
  input  logic rdwait_en,
  input  logic gapirq_en,
  input  logic bus_wide4,
  input  logic stop_req,
  input  logic cont_wr,
  input  logic blk_done,
  input  logic last_blk,
  input  logic dat_active,
  input  logic wr_active,
  output logic pause,
  output logic read_wait,
  output logic gap_irq_win,
  output logic data_wr_block,
  output logic cont_bit,
  output logic xfer_done
);
  gpc_state_e state;
  logic       cont_accept;
  logic       restarted;
  gpc_cfg_t   cfg_in;

  assign cfg_in = '{rd: dir_read, rw_en: rdwait_en, irq_en: gapirq_en, wide4: bus_wide4};

  gpc_seq seq_i (
    .clk(clk), .rst_n(rst_n), .start(xfer_start), .blk_done(blk_done),
    .last_blk(last_blk), .stop_req(stop_req), .cont_accept(cont_accept),
    .restarted(restarted), .state(state), .done_pulse(xfer_done)
  );

  gpc_cont cont_i (
    .clk(clk), .rst_n(rst_n), .state(state), .cont_wr(cont_wr),
    .stop_req(stop_req), .dat_active(dat_active), .wr_active(wr_active),
    .cont_accept(cont_accept), .restarted(restarted), .cont_bit(cont_bit)
  );

  gpc_outs outs_i (
    .clk(clk), .rst_n(rst_n), .state(state), .start(xfer_start),
    .cfg_in(cfg_in), .stop_req(stop_req), .pause(pause),
    .read_wait(read_wait), .gap_irq_win(gap_irq_win),
    .data_wr_block(data_wr_block)
  );
endmodule

// File: rtl/gap_pause_ctrl_chk.sv
module gap_pause_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic stop_req,
  input logic cont_wr,
  input logic blk_done,
  input logic dat_active,
  input logic wr_active,
  input logic pause,
  input logic read_wait,
  input logic gap_irq_win,
  input logic data_wr_block,
  input logic cont_bit,
  input logic xfer_done
);
  a_r8_rdwait_only_paused: assert property (@(posedge clk) disable iff (!rst_n)
    read_wait |-> pause);
  a_r9_irqwin_only_paused: assert property (@(posedge clk) disable iff (!rst_n)
    gap_irq_win |-> pause);
  a_r3_pause_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pause) |-> $past(blk_done && stop_req));
  a_r4_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done);
  a_r5_continue_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (pause && cont_wr && !stop_req) |=> (!pause && cont_bit));
  a_r6_continue_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (pause && cont_wr && stop_req) |=> (pause && !cont_bit));
  a_r7_cont_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (cont_bit && (dat_active || wr_active)) |=> !cont_bit);
  a_r7_cont_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cont_bit && !dat_active && !wr_active) |=> cont_bit);
  a_r10_block_needs_stop: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr_block |-> stop_req);
endmodule

bind gap_pause_ctrl gap_pause_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .cont_wr(cont_wr),
  .blk_done(blk_done), .dat_active(dat_active), .wr_active(wr_active),
  .pause(pause), .read_wait(read_wait), .gap_irq_win(gap_irq_win),
  .data_wr_block(data_wr_block), .cont_bit(cont_bit), .xfer_done(xfer_done)
);

// File: tb/gap_pause_ctrl_tb_top.sv
module gap_pause_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xfer_start = 0, dir_read = 0, rdwait_en = 0, gapirq_en = 0, bus_wide4 = 0;
  logic stop_req = 0, cont_wr = 0, blk_done = 0, last_blk = 0;
  logic dat_active = 0, wr_active = 0;
  logic pause, read_wait, gap_irq_win, data_wr_block, cont_bit, xfer_done;
  int   n_run = 0, n_fail = 0;
  bit   finished = 0;

  always #4 clk = ~clk;

  gap_pause_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .dir_read(dir_read),
    .rdwait_en(rdwait_en), .gapirq_en(gapirq_en), .bus_wide4(bus_wide4),
    .stop_req(stop_req), .cont_wr(cont_wr), .blk_done(blk_done),
    .last_blk(last_blk), .dat_active(dat_active), .wr_active(wr_active),
    .pause(pause), .read_wait(read_wait), .gap_irq_win(gap_irq_win),
    .data_wr_block(data_wr_block), .cont_bit(cont_bit), .xfer_done(xfer_done)
  );

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  initial begin
    #(8 * 20000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    step();
    chk("R1", "pause", pause, 1'b0);
    chk("R1", "read_wait", read_wait, 1'b0);
    chk("R1", "gap_irq_win", gap_irq_win, 1'b0);
    chk("R1", "data_wr_block", data_wr_block, 1'b0);
    chk("R1", "cont_bit", cont_bit, 1'b0);
    chk("R1", "xfer_done", xfer_done, 1'b0);
    rst_n = 1'b1;
    step();
    for (int c = 0; c < 16; c++) begin
      logic exp_rw, exp_irq;
      dir_read = c[0]; rdwait_en = c[1]; gapirq_en = c[2]; bus_wide4 = c[3];
      exp_rw  = c[0] & c[1];
      exp_irq = c[2] & c[3];
      // R2: start, then an ordinary block boundary
      xfer_start = 1; step(); xfer_start = 0;
      dir_read = ~dir_read; rdwait_en = ~rdwait_en; gapirq_en = ~gapirq_en; bus_wide4 = ~bus_wide4;
      chk("R2", "pause after start", pause, 1'b0);
      blk_done = 1; step(); blk_done = 0;
      chk("R2", "pause after plain block", pause, 1'b0);
      // R3: stop request alone does not pause
      stop_req = 1; step();
      chk("R3", "pause before gap", pause, 1'b0);
      chk("R10", "data_wr_block running", data_wr_block, 1'b1);
      blk_done = 1; step(); blk_done = 0;
      chk("R3", "pause at gap", pause, 1'b1);
      chk("R8", "read_wait", read_wait, exp_rw);
      chk("R9", "gap_irq_win", gap_irq_win, exp_irq);
      // R11: start ignored while paused
      xfer_start = 1; step(); xfer_start = 0;
      chk("R11", "pause kept", pause, 1'b1);
      chk("R8", "read_wait after restart try", read_wait, exp_rw);
      // R6: continue with stop still set
      cont_wr = 1; step(); cont_wr = 0;
      chk("R6", "pause kept", pause, 1'b1);
      chk("R6", "cont_bit", cont_bit, 1'b0);
      // R5: continue accepted
      stop_req = 0; step();
      chk("R10", "data_wr_block stop low", data_wr_block, 1'b0);
      cont_wr = 1; step(); cont_wr = 0;
      chk("R5", "pause released", pause, 1'b0);
      chk("R5", "cont_bit set", cont_bit, 1'b1);
      chk("R8", "read_wait released", read_wait, 1'b0);
      step();
      chk("R7", "cont_bit held", cont_bit, 1'b1);
      if (c[0]) dat_active = 1; else wr_active = 1;
      step(); dat_active = 0; wr_active = 0;
      chk("R7", "cont_bit cleared", cont_bit, 1'b0);
      // R4: last block ends transfer, stop set in half of the runs
      stop_req = c[1];
      blk_done = 1; last_blk = 1; step(); blk_done = 0; last_blk = 0;
      chk("R4", "xfer_done", xfer_done, 1'b1);
      chk("R4", "no pause", pause, 1'b0);
      step();
      chk("R4", "xfer_done one cycle", xfer_done, 1'b0);
      stop_req = 1; step();
      chk("R10", "data_wr_block idle", data_wr_block, 1'b0);
      stop_req = 0;
    end
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule